// File: doc/BRIEF.md
# Multicycle Multiplier with Data-Dependent Latency

This block multiplies two 32-bit operands over several clock cycles and can add an accumulator to the product. In short mode it returns a 32-bit result. In long mode it returns a 64-bit result split into a high word and a low word. The long product treats the operands as two's-complement or as unsigned values, under the control of a single signed input. When asked to, it also reports a zero flag and a negative flag for the result.

The latency models early termination. A fixed base count depends on the mode and on whether an accumulate is requested. The multiplier operand (`op_b`) then adds one cycle for each upper byte boundary whose remaining high bits still carry information. The whole count is worked out when the command is accepted.

The unit takes a one-cycle `start` when it is idle. It stays `busy` while it counts down, then raises `done` for one cycle. The result and the flags stay on the outputs until the next command completes.

Top module: `mul_early_term`

## Requirements
- R1: A command is accepted on a clock edge where `start` is high and `busy` is low. The next cycle holds `busy` high. If N is the computed cycle count, `done` is high for exactly one cycle, N+1 cycles after the accepting edge, and `busy` is low in that cycle.
- R2: The base part of N is 2 for a long command plus 1 when accumulating. For a short command it is 0, plus 1 when accumulating.
- R3: With `is_signed` low, N gains 1 for each of `op_b>>8`, `op_b>>16` and `op_b>>24` that is nonzero.
- R4: With `is_signed` high, N gains 1 for each of those three shifted values that is neither all zeros nor all ones (0xFFFFFF, 0xFFFF, 0xFF in turn).
- R5: A short result places the low 32 bits of `op_a*op_b` on `res_lo`. When `do_acc` is high it adds `acc_lo` first. `res_hi` is zero.
- R6: A long result is the 64-bit product of both operands, each extended to 64 bits by sign when `is_signed` is high and by zero when it is low. `res_hi` holds bits 63..32 and `res_lo` holds bits 31..0.
- R7: A long command with `do_acc` high adds the 64-bit value {`acc_hi`,`acc_lo`} to the product, modulo 2^64.
- R8: A long command with `set_flags` high sets `flag_z` only when all 64 result bits are zero. It copies bit 63 to `flag_n`.
- R9: A short command with `set_flags` high sets `flag_z` when the 32-bit result is zero. It copies bit 31 to `flag_n`.
- R10: A command with `set_flags` low leaves `flag_z` and `flag_n` unchanged.
- R11: `res_hi`, `res_lo` and the flags change only on the edge that raises `done`. They hold their values until the next completion.
- R12: A `start` seen while `busy` is high is ignored. It does not alter the running count, the result or the flags.
- R13: While `rst` is high, `busy`, `done`, `res_hi`, `res_lo`, `flag_z` and `flag_n` all read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command request, sampled when idle |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier; its magnitude sets the latency |
| acc_hi | input | 32 | Accumulator high word (long mode) |
| acc_lo | input | 32 | Accumulator low word |
| is_long | input | 1 | 1: 64-bit result, 0: 32-bit result |
| is_signed | input | 1 | 1: two's-complement operands and signed latency rule |
| do_acc | input | 1 | Add the accumulator |
| set_flags | input | 1 | Update zero and negative flags |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| res_hi | output | 32 | Result high word |
| res_lo | output | 32 | Result low word |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |

## Verification
`busy` is due one cycle after the accepting edge. `done`, the result words and the flags are due N+1 cycles after it, with N worked out from the mode bits and the byte boundaries of `op_b`. The bench model takes the inputs at each rising edge and steps the same countdown. The outputs are compared with it at every falling edge, so each result is checked in the exact cycle it is due and in every cycle it is held. The corner cases cover zero-extra and three-extra operands in both sign modes, a start issued in the `done` cycle, and starts while busy.

// File: rtl/mul_pkg.sv
package mul_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic is_long;
        logic is_signed;
        logic do_acc;
        logic set_flags;
    } mul_ctl_t;

    // Fixed cycles before data-dependent extras (R2)
    function automatic logic [1:0] base_cycles(input logic is_long, input logic do_acc);
        logic [1:0] n;
        n = is_long ? 2'd2 : 2'd0;
        n = n + {1'b0, do_acc};
        return n;
    endfunction

endpackage

// File: rtl/mul_cycle_calc.sv
module mul_cycle_calc
    import mul_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 3
) (
    input  logic [DW-BYTE_W-1:0] mult_hi,
    input  logic                 is_long,
    input  logic                 is_signed,
    input  logic                 do_acc,
    output logic [CW-1:0]        cycles
);
    localparam int NB = DW / BYTE_W;

    logic [NB-1:0] extra;
    assign extra[0] = 1'b0;

    genvar k;
    generate
        for (k = 1; k < NB; k++) begin : g_bnd
            localparam int UW = DW - BYTE_W * k;
            logic [UW-1:0] upper;
            logic          all_zero;
            logic          all_one;
            assign upper    = mult_hi[DW-BYTE_W-1 -: UW];
            assign all_zero = ~|upper;
            assign all_one  = &upper;
            assign extra[k] = is_signed ? ~(all_zero | all_one) : ~all_zero;
        end
    endgenerate

    always_comb begin
        cycles = CW'(base_cycles(is_long, do_acc));
        for (int i = 1; i < NB; i++) begin
            cycles = cycles + CW'(extra[i]);
        end
    end

endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] acc_hi,
    input  logic [DW-1:0] acc_lo,
    input  logic          is_long,
    input  logic          is_signed,
    input  logic          do_acc,
    output logic [DW-1:0] out_hi,
    output logic [DW-1:0] out_lo,
    output logic          out_z,
    output logic          out_n
);
    localparam int PW = 2 * DW;

    logic [PW-1:0] a_ext;
    logic [PW-1:0] b_ext;
    logic [PW-1:0] prod;
    logic [PW-1:0] sum_long;
    logic [DW-1:0] sum_short;

    always_comb begin
        a_ext     = is_signed ? {{DW{a[DW-1]}}, a} : {{DW{1'b0}}, a};
        b_ext     = is_signed ? {{DW{b[DW-1]}}, b} : {{DW{1'b0}}, b};
        prod      = a_ext * b_ext;
        sum_long  = prod + (do_acc ? {acc_hi, acc_lo} : {PW{1'b0}});
        sum_short = prod[DW-1:0] + (do_acc ? acc_lo : {DW{1'b0}});
        if (is_long) begin
            out_hi = sum_long[PW-1:DW];
            out_lo = sum_long[DW-1:0];
            out_z  = ~|sum_long;
            out_n  = sum_long[PW-1];
        end else begin
            out_hi = '0;
            out_lo = sum_short;
            out_z  = ~|sum_short;
            out_n  = sum_short[DW-1];
        end
    end

endmodule

// File: rtl/mul_seq.sv
module mul_seq #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] cycles,
    output logic          busy,
    output logic          done,
    output logic          load,
    output logic          finish
);
    logic [CW-1:0] remain;

    assign load   = start & ~busy;
    assign finish = busy & (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            remain <= '0;
        end else begin
            done <= finish;
            if (finish) begin
                busy <= 1'b0;
            end else if (busy) begin
                remain <= remain - 1'b1;
            end else if (load) begin
                busy   <= 1'b1;
                remain <= cycles;
            end
        end
    end

endmodule

// File: rtl/mul_early_term.sv
module mul_early_term
    import mul_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic [DW-1:0] acc_hi,
    input  logic [DW-1:0] acc_lo,
    input  logic          is_long,
    input  logic          is_signed,
    input  logic          do_acc,
    input  logic          set_flags,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] res_hi,
    output logic [DW-1:0] res_lo,
    output logic          flag_z,
    output logic          flag_n
);
    localparam int NB = DW / BYTE_W;
    localparam int CW = $clog2(NB + 3);

    mul_ctl_t      ctl_q;
    logic [DW-1:0] a_q, b_q, hi_q, lo_q;
    logic [CW-1:0] cycles;
    logic          load, finish;
    logic [DW-1:0] dp_hi, dp_lo;
    logic          dp_z, dp_n;

    mul_cycle_calc #(.DW(DW), .CW(CW)) calc_i (
        .mult_hi   (op_b[DW-1:BYTE_W]),
        .is_long   (is_long),
        .is_signed (is_signed),
        .do_acc    (do_acc),
        .cycles    (cycles)
    );

    mul_seq #(.CW(CW)) seq_i (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .cycles (cycles),
        .busy   (busy),
        .done   (done),
        .load   (load),
        .finish (finish)
    );

    mul_datapath #(.DW(DW)) dp_i (
        .a         (a_q),
        .b         (b_q),
        .acc_hi    (hi_q),
        .acc_lo    (lo_q),
        .is_long   (ctl_q.is_long),
        .is_signed (ctl_q.is_signed),
        .do_acc    (ctl_q.do_acc),
        .out_hi    (dp_hi),
        .out_lo    (dp_lo),
        .out_z     (dp_z),
        .out_n     (dp_n)
    );

    // Command capture on acceptance
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            a_q   <= '0;
            b_q   <= '0;
            hi_q  <= '0;
            lo_q  <= '0;
        end else if (load) begin
            ctl_q <= '{is_long: is_long, is_signed: is_signed,
                       do_acc: do_acc, set_flags: set_flags};
            a_q   <= op_a;
            b_q   <= op_b;
            hi_q  <= acc_hi;
            lo_q  <= acc_lo;
        end
    end

    // Result and flag registers, written only at completion
    always_ff @(posedge clk) begin
        if (rst) begin
            res_hi <= '0;
            res_lo <= '0;
            flag_z <= 1'b0;
            flag_n <= 1'b0;
        end else if (finish) begin
            res_hi <= dp_hi;
            res_lo <= dp_lo;
            if (ctl_q.set_flags) begin
                flag_z <= dp_z;
                flag_n <= dp_n;
            end
        end
    end

endmodule

// File: rtl/mul_early_term_chk.sv
module mul_early_term_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [DW-1:0] res_hi,
    input logic [DW-1:0] res_lo,
    input logic          flag_z,
    input logic          flag_n
);

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy)); // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(res_hi) && $stable(res_lo))); // R11

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(flag_z) && $stable(flag_n))); // R10

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done)); // R12

endmodule

bind mul_early_term mul_early_term_chk #(.DW(DW)) chk_i (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .res_hi (res_hi),
    .res_lo (res_lo),
    .flag_z (flag_z),
    .flag_n (flag_n)
);

// File: tb/mul_early_term_tb_top.sv
module mul_early_term_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, acc_hi = '0, acc_lo = '0;
    logic        is_long = 1'b0, is_signed = 1'b0, do_acc = 1'b0, set_flags = 1'b0;
    logic        busy, done, flag_z, flag_n;
    logic [31:0] res_hi, res_lo;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mul_early_term dut_i (
        .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
        .acc_hi(acc_hi), .acc_lo(acc_lo), .is_long(is_long),
        .is_signed(is_signed), .do_acc(do_acc), .set_flags(set_flags),
        .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo),
        .flag_z(flag_z), .flag_n(flag_n)
    );

    // ---------------- reference model ----------------
    logic        m_busy = 0, m_done = 0, m_z = 0, m_n = 0;
    logic [31:0] m_hi = 0, m_lo = 0;
    int          m_cnt = 0;
    logic [31:0] p_hi, p_lo;
    logic        p_z, p_n, p_flags;
    string       lat_tag = "R13", res_tag = "R13", flg_tag = "R13";
    string       p_res_tag, p_flg_tag;

    function automatic int exp_cycles(logic [31:0] b, logic lng, logic sgn, logic acc);
        int n;
        n = (lng ? 2 : 0) + (acc ? 1 : 0);
        for (int k = 1; k <= 3; k++) begin
            logic [31:0] sh, ones;
            sh   = b >> (8 * k);
            ones = 32'hFFFF_FFFF >> (8 * k);
            if (sgn) begin
                if (sh != 0 && sh != ones) n++;
            end else begin
                if (sh != 0) n++;
            end
        end
        return n;
    endfunction

    task automatic model_accept();
        logic [63:0] ea, eb, pr, sum;
        logic [31:0] s32;
        ea  = is_signed ? {{32{op_a[31]}}, op_a} : {32'd0, op_a};
        eb  = is_signed ? {{32{op_b[31]}}, op_b} : {32'd0, op_b};
        pr  = ea * eb;
        sum = pr + (do_acc ? {acc_hi, acc_lo} : 64'd0);
        s32 = pr[31:0] + (do_acc ? acc_lo : 32'd0);
        if (is_long) begin
            p_hi = sum[63:32]; p_lo = sum[31:0];
            p_z = (sum == 64'd0); p_n = sum[63];
            p_res_tag = do_acc ? "R7" : "R6";
            p_flg_tag = "R8";
        end else begin
            p_hi = 32'd0; p_lo = s32;
            p_z = (s32 == 32'd0); p_n = s32[31];
            p_res_tag = "R5";
            p_flg_tag = "R9";
        end
        p_flags = set_flags;
        if (!set_flags) p_flg_tag = "R10";
        m_cnt   = exp_cycles(op_b, is_long, is_signed, do_acc);
        lat_tag = is_signed ? "R1 R4" : (m_cnt > (is_long ? 2 : 0) + (do_acc ? 1 : 0) ? "R1 R3" : "R1 R2");
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_hi = 0; m_lo = 0; m_z = 0; m_n = 0;
            lat_tag = "R13"; res_tag = "R13"; flg_tag = "R13";
        end else begin
            if (m_done) begin
                res_tag = "R11";
                if (flg_tag != "R10") flg_tag = "R11";
            end
            m_done = 0;
            if (m_busy) begin
                if (start) lat_tag = "R12";
                if (m_cnt == 0) begin
                    m_busy = 0; m_done = 1;
                    m_hi = p_hi; m_lo = p_lo;
                    res_tag = p_res_tag; flg_tag = p_flg_tag;
                    if (p_flags) begin m_z = p_z; m_n = p_n; end
                end else begin
                    m_cnt--;
                end
            end else if (start) begin
                m_busy = 1;
                model_accept();
            end
        end
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        chk(lat_tag, "busy", {31'd0, busy}, {31'd0, m_busy});
        chk(lat_tag, "done", {31'd0, done}, {31'd0, m_done});
        chk(res_tag, "res_hi", res_hi, m_hi);
        chk(res_tag, "res_lo", res_lo, m_lo);
        chk(flg_tag, "flag_z", {31'd0, flag_z}, {31'd0, m_z});
        chk(flg_tag, "flag_n", {31'd0, flag_n}, {31'd0, m_n});
    end

    // ---------------- stimulus ----------------
    task automatic drive(logic [31:0] a, logic [31:0] b, logic [31:0] h, logic [31:0] l,
                         logic lng, logic sgn, logic acc, logic fl);
        op_a = a; op_b = b; acc_hi = h; acc_lo = l;
        is_long = lng; is_signed = sgn; do_acc = acc; set_flags = fl;
    endtask

    task automatic run(logic [31:0] a, logic [31:0] b, logic [31:0] h, logic [31:0] l,
                       logic lng, logic sgn, logic acc, logic fl);
        @(negedge clk);
        drive(a, b, h, l, lng, sgn, acc, fl);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;                                    // R13 checked during reset
        // R2 R3: unsigned, no extras / one / two / three
        run(32'd7, 32'd9, 0, 0, 0, 0, 0, 1);           // R5 R9
        run(32'd3, 32'h0000_0100, 0, 0, 0, 0, 0, 1);   // R3
        run(32'd3, 32'h0001_0000, 0, 0, 1, 0, 0, 1);   // R3 R6
        run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 1, 0, 0, 1); // R3 R6 R8
        // R4: signed rules
        run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 1, 1, 0, 1); // R4 R6, zero extras
        run(32'd5, 32'hFFFF_FF80, 0, 0, 1, 1, 0, 1);   // R4 negative product R8
        run(32'd5, 32'hFFFF_0000, 0, 0, 1, 1, 1, 1);   // R4 one extra, R7
        run(32'd5, 32'h0080_0000, 0, 0, 0, 1, 0, 1);   // R4 short signed
        // R7 R8: accumulate to exact zero
        run(32'hFFFF_FFFF, 32'd1, 32'd0, 32'd1, 1, 1, 1, 1);
        // R5 R9: short accumulate wrapping to zero
        run(32'd2, 32'h8000_0000, 0, 32'd0, 0, 0, 1, 1);
        run(32'd1, 32'd1, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 0, 0, 1, 1);
        // R10: flags untouched
        run(32'd6, 32'd7, 0, 0, 1, 0, 0, 0);
        run(32'd0, 32'd0, 0, 0, 0, 0, 0, 0);
        // R12: starts while busy are ignored
        @(negedge clk);
        drive(32'h1234_5678, 32'h7654_3210, 32'h1, 32'h2, 1, 0, 1, 1);
        start = 1'b1;
        @(negedge clk);
        drive(32'd0, 32'd0, 0, 0, 0, 0, 0, 1);
        repeat (3) @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        // R1: new start in the done cycle
        drive(32'd11, 32'd13, 0, 0, 0, 0, 0, 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        // pseudo-random mix
        begin
            logic [31:0] lf;
            lf = 32'hACE1_2468;
            for (int i = 0; i < 40; i++) begin
                logic [31:0] a, b;
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                a  = lf;
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                b  = lf >> (lf[4:3] * 8);
                run(a, b, ~a, lf ^ a, lf[5], lf[6], lf[7], lf[8]);
            end
        end
        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule